// File: doc/BRIEF.md
# T1 Superframe Timing Generator

This block turns a frame-alignment indication from an external framer into the set of receive-side timing strobes that a T1 receiver needs. It counts the 193 bit times of each frame: one framing bit, then 24 eight-bit channels. It also counts frames within a 12-frame superframe or a 24-frame extended superframe, chosen by a format input. From these counts it decodes a frame sync, a channel clock, a multiframe sync, a signaling-frame flag, a signaling-select clock, and a data-link clock with its data.

The framing bits of the link frames are taken from the received serial data and presented on the link data output. Link frames are the odd frames in extended-superframe mode and the even frames in superframe mode. A resync flag from the framer silences every strobe while it is high. The counters keep running underneath, so the strobes return in phase when the flag drops. A new alignment pulse restarts both counters at any point in a frame.

Top module: `t1_sf_timing`

## Requirements
- R1: After reset, and until the first alignment pulse, every output is low.
- R2: The clock cycle after an alignment pulse is the framing bit of frame 1. After that, `fsync_o` is high for exactly one cycle in every 193.
- R3: `chclk_o` is low during the framing bit. It is high for the first 4 of the 8 bit times of each channel and low for the other 4.
- R4: `msync_o` is high during the first half of the multiframe and low during the second half. That is frames 1 to 6 in superframe mode (`esf_sel`=0) and frames 1 to 12 in extended-superframe mode (`esf_sel`=1).
- R5: `sigfr_o` is high for whole frames 6 and 12 in superframe mode, and for frames 6, 12, 18 and 24 in extended-superframe mode. It is low in all other frames.
- R6: `sigsel_o` is high in frames 1-6 and 13-18 in extended-superframe mode, so it is high in the A and C signaling frames. In superframe mode it is high in frames 1-3 and 7-9.
- R7: In each link frame, the framing bit is captured from `line_data`. Link frames are odd frames in extended-superframe mode and even frames in superframe mode. In the last-but-one bit time of the frame before the next link frame, the captured bit moves to `link_data_o`, which holds it until the next transfer.
- R8: `link_clk_o` is high for the whole of every link frame and low in the other frames.
- R9: While `resync` is high, every output is low and the counters keep running. When `resync` drops, the strobes resume in their previous phase.
- R10: An alignment pulse in the middle of a frame restarts the bit and frame counts. The frame count wraps after the last frame of the selected format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_line | input | 1 | Line bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| align_pulse | input | 1 | One-cycle frame-alignment indication; the next cycle is the framing bit of frame 1 |
| esf_sel | input | 1 | Format: 0 = 12-frame superframe, 1 = 24-frame extended superframe |
| resync | input | 1 | Framer is searching; silences all outputs |
| line_data | input | 1 | Received NRZ serial data |
| fsync_o | output | 1 | Frame sync, one cycle at the framing bit |
| chclk_o | output | 1 | Channel clock marking 8-bit timeslots |
| msync_o | output | 1 | Multiframe sync, 50% duty |
| sigfr_o | output | 1 | Signaling-frame flag |
| sigsel_o | output | 1 | Signaling-select clock |
| link_clk_o | output | 1 | Data-link clock, high during link frames |
| link_data_o | output | 1 | Extracted data-link bit |

## Verification
The bench targets alignment pulses that land in the middle of a frame. A design that only realigned at frame boundaries would keep its strobes one partial frame out of phase. It also switches the format together with a realignment. A decode that kept the old frame length or the old link parity would then put the link clock and the signaling flags in the wrong frames. A resync window that opens and closes mid-frame shows whether the counters really kept running: a design that froze them would come back shifted. Random line data shows whether the link bit is captured from the right frame parity and moved on the right bit time. A one-frame or one-bit slip would show up as a stale or early bit on `link_data_o`.

// File: rtl/t1tg_pkg.sv
package t1tg_pkg;
   typedef struct packed {
      logic fsync;
      logic chclk;
      logic msync;
      logic sigfr;
      logic sigsel;
      logic lclk;
      logic ldata;
   } strb_t;

   localparam strb_t STRB_IDLE = '0;
endpackage

// File: rtl/t1tg_bit_ctr.sv
module t1tg_bit_ctr #(
   parameter int SLOTS     = 24,
   parameter int SLOT_BITS = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         align,
   output logic                         is_fbit,
   output logic                         last_bit,
   output logic                         pre_last,
   output logic [$clog2(SLOT_BITS)-1:0] slot_bit
);
   localparam int FRAME_BITS = 1 + SLOTS * SLOT_BITS;
   localparam int BIT_W      = $clog2(FRAME_BITS);
   localparam int SB_W       = $clog2(SLOT_BITS);
   localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_BITS - 1);
   localparam logic [BIT_W-1:0] PRE_IDX  = BIT_W'(FRAME_BITS - 2);
   localparam logic [SB_W-1:0]  SB_LAST  = SB_W'(SLOT_BITS - 1);

   logic [BIT_W-1:0] bit_q;
   logic [SB_W-1:0]  sb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q <= '0;
         sb_q  <= '0;
      end else if (align || bit_q == LAST_IDX) begin
         bit_q <= '0;
         sb_q  <= '0;
      end else begin
         bit_q <= bit_q + 1'b1;
         if (bit_q == '0 || sb_q == SB_LAST)
            sb_q <= '0;
         else
            sb_q <= sb_q + 1'b1;
      end
   end

   assign is_fbit  = (bit_q == '0);
   assign last_bit = (bit_q == LAST_IDX);
   assign pre_last = (bit_q == PRE_IDX);
   assign slot_bit = sb_q;
endmodule

// File: rtl/t1tg_frame_ctr.sv
module t1tg_frame_ctr #(
   parameter int SF_FRAMES   = 12,
   parameter int SIG_SPACING = 6
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           align,
   input  logic                                           esf,
   input  logic                                           adv,
   output logic [$clog2(2*SF_FRAMES)-1:0]                 frm,
   output logic [$clog2(SIG_SPACING)-1:0]                 sig_ph,
   output logic [$clog2(2*SF_FRAMES/SIG_SPACING)-1:0]     grp
);
   localparam int ESF_FRAMES = 2 * SF_FRAMES;
   localparam int FRM_W      = $clog2(ESF_FRAMES);
   localparam int PH_W       = $clog2(SIG_SPACING);
   localparam int GRP_W      = $clog2(ESF_FRAMES / SIG_SPACING);
   localparam logic [FRM_W-1:0] SF_LAST  = FRM_W'(SF_FRAMES - 1);
   localparam logic [FRM_W-1:0] ESF_LAST = FRM_W'(ESF_FRAMES - 1);
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SIG_SPACING - 1);

   logic [FRM_W-1:0] frm_q;
   logic [PH_W-1:0]  ph_q;
   logic [GRP_W-1:0] grp_q;
   logic             wrap;

   assign wrap = (frm_q >= (esf ? ESF_LAST : SF_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frm_q <= '0;
         ph_q  <= '0;
         grp_q <= '0;
      end else if (align || (adv && wrap)) begin
         frm_q <= '0;
         ph_q  <= '0;
         grp_q <= '0;
      end else if (adv) begin
         frm_q <= frm_q + 1'b1;
         if (ph_q == PH_LAST) begin
            ph_q  <= '0;
            grp_q <= grp_q + 1'b1;
         end else begin
            ph_q <= ph_q + 1'b1;
         end
      end
   end

   assign frm    = frm_q;
   assign sig_ph = ph_q;
   assign grp    = grp_q;
endmodule

// File: rtl/t1tg_link.sv
module t1tg_link (
   input  logic clk,
   input  logic rst_n,
   input  logic line_data,
   input  logic is_fbit,
   input  logic pre_last,
   input  logic link_frame,
   output logic ldq
);
   logic hold_q;
   logic out_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         out_q  <= 1'b0;
      end else begin
         if (is_fbit && link_frame)
            hold_q <= line_data;
         if (pre_last && !link_frame)
            out_q <= hold_q;
      end
   end

   assign ldq = out_q;
endmodule

// File: rtl/t1tg_strobe_dec.sv
module t1tg_strobe_dec
   import t1tg_pkg::*;
#(
   parameter int SF_FRAMES   = 12,
   parameter int SIG_SPACING = 6,
   parameter int SLOT_BITS   = 8,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       act,
   input  logic                                       esf,
   input  logic                                       is_fbit,
   input  logic [$clog2(SLOT_BITS)-1:0]               slot_bit,
   input  logic [$clog2(2*SF_FRAMES)-1:0]             frm,
   input  logic [$clog2(SIG_SPACING)-1:0]             sig_ph,
   input  logic [$clog2(2*SF_FRAMES/SIG_SPACING)-1:0] grp,
   input  logic                                       link_frame,
   input  logic                                       ldq,
   output strb_t                                      strb
);
   localparam int FRM_W = $clog2(2 * SF_FRAMES);
   localparam int PH_W  = $clog2(SIG_SPACING);
   localparam int SB_W  = $clog2(SLOT_BITS);
   localparam logic [FRM_W-1:0] SF_HALF  = FRM_W'(SF_FRAMES / 2);
   localparam logic [FRM_W-1:0] ESF_HALF = FRM_W'(SF_FRAMES);
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SIG_SPACING - 1);
   localparam logic [PH_W-1:0]  PH_HALF  = PH_W'(SIG_SPACING / 2);
   localparam logic [SB_W-1:0]  SB_HALF  = SB_W'(SLOT_BITS / 2);

   strb_t nxt;

   always_comb begin
      nxt = STRB_IDLE;
      if (act) begin
         nxt.fsync  = is_fbit;
         nxt.chclk  = !is_fbit && (slot_bit < SB_HALF);
         nxt.msync  = frm < (esf ? ESF_HALF : SF_HALF);
         nxt.sigfr  = (sig_ph == PH_LAST);
         nxt.sigsel = esf ? !grp[0] : (sig_ph < PH_HALF);
         nxt.lclk   = link_frame;
         nxt.ldata  = ldq;
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         strb_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= STRB_IDLE;
            else        q <= nxt;
         end
         assign strb = q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign strb = nxt;
      end
   endgenerate
endmodule

// File: rtl/t1_sf_timing.sv
module t1_sf_timing
   import t1tg_pkg::*;
#(
   parameter int SLOTS       = 24,
   parameter int SLOT_BITS   = 8,
   parameter int SF_FRAMES   = 12,
   parameter int SIG_SPACING = 6,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic clk_line,
   input  logic rst_n,
   input  logic align_pulse,
   input  logic esf_sel,
   input  logic resync,
   input  logic line_data,
   output logic fsync_o,
   output logic chclk_o,
   output logic msync_o,
   output logic sigfr_o,
   output logic sigsel_o,
   output logic link_clk_o,
   output logic link_data_o
);
   localparam int ESF_FRAMES = 2 * SF_FRAMES;
   localparam int FRM_W      = $clog2(ESF_FRAMES);
   localparam int PH_W       = $clog2(SIG_SPACING);
   localparam int GRP_W      = $clog2(ESF_FRAMES / SIG_SPACING);
   localparam int SB_W       = $clog2(SLOT_BITS);

   initial begin : elab_chk
      assert (SLOT_BITS >= 2 && SLOT_BITS % 2 == 0)
         else $error("slot width must be even and at least 2");
      assert (SLOTS >= 2)
         else $error("need at least two slots per frame");
      assert (SF_FRAMES % 2 == 0 && SF_FRAMES % SIG_SPACING == 0)
         else $error("superframe length must be even and a multiple of the signaling spacing");
      assert (SIG_SPACING >= 2)
         else $error("signaling spacing too small");
      assert ((ESF_FRAMES / SIG_SPACING) % 2 == 0)
         else $error("extended format needs an even count of signaling groups");
   end

   logic             locked_q;
   logic             act;
   logic             is_fbit, last_bit, pre_last;
   logic [SB_W-1:0]  slot_bit;
   logic [FRM_W-1:0] frm;
   logic [PH_W-1:0]  sig_ph;
   logic [GRP_W-1:0] grp;
   logic             link_frame;
   logic             ldq;
   strb_t            strb;

   always_ff @(posedge clk_line or negedge rst_n) begin
      if (!rst_n)           locked_q <= 1'b0;
      else if (align_pulse) locked_q <= 1'b1;
   end

   assign act        = locked_q && !resync;
   assign link_frame = esf_sel ? !frm[0] : frm[0];

   t1tg_bit_ctr #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_bit (
      .clk      (clk_line),
      .rst_n    (rst_n),
      .align    (align_pulse),
      .is_fbit  (is_fbit),
      .last_bit (last_bit),
      .pre_last (pre_last),
      .slot_bit (slot_bit)
   );

   t1tg_frame_ctr #(.SF_FRAMES(SF_FRAMES), .SIG_SPACING(SIG_SPACING)) u_frm (
      .clk    (clk_line),
      .rst_n  (rst_n),
      .align  (align_pulse),
      .esf    (esf_sel),
      .adv    (last_bit),
      .frm    (frm),
      .sig_ph (sig_ph),
      .grp    (grp)
   );

   t1tg_link u_link (
      .clk        (clk_line),
      .rst_n      (rst_n),
      .line_data  (line_data),
      .is_fbit    (is_fbit),
      .pre_last   (pre_last),
      .link_frame (link_frame),
      .ldq        (ldq)
   );

   t1tg_strobe_dec #(
      .SF_FRAMES   (SF_FRAMES),
      .SIG_SPACING (SIG_SPACING),
      .SLOT_BITS   (SLOT_BITS),
      .OUT_REG     (OUT_REG)
   ) u_dec (
      .clk        (clk_line),
      .rst_n      (rst_n),
      .act        (act),
      .esf        (esf_sel),
      .is_fbit    (is_fbit),
      .slot_bit   (slot_bit),
      .frm        (frm),
      .sig_ph     (sig_ph),
      .grp        (grp),
      .link_frame (link_frame),
      .ldq        (ldq),
      .strb       (strb)
   );

   assign fsync_o     = strb.fsync;
   assign chclk_o     = strb.chclk;
   assign msync_o     = strb.msync;
   assign sigfr_o     = strb.sigfr;
   assign sigsel_o    = strb.sigsel;
   assign link_clk_o  = strb.lclk;
   assign link_data_o = strb.ldata;
endmodule

// File: rtl/t1tg_checker.sv
module t1tg_checker (
   input logic clk_line,
   input logic rst_n,
   input logic align_pulse,
   input logic esf_sel,
   input logic resync,
   input logic fsync_o,
   input logic chclk_o,
   input logic msync_o,
   input logic sigfr_o,
   input logic sigsel_o,
   input logic link_clk_o,
   input logic link_data_o
);
   AST_FSYNC_SINGLE: assert property (@(posedge clk_line) disable iff (!rst_n)
      (fsync_o && !align_pulse) |=> !fsync_o); // R2

   AST_CHCLK_OFF_FBIT: assert property (@(posedge clk_line) disable iff (!rst_n)
      fsync_o |-> !chclk_o); // R3

   AST_MSYNC_RISE_AT_F: assert property (@(posedge clk_line) disable iff (!rst_n)
      ($rose(msync_o) && $past(!resync) && $stable(esf_sel)) |-> fsync_o); // R4

   AST_SIGFR_LINK_PHASE: assert property (@(posedge clk_line) disable iff (!rst_n)
      (sigfr_o && $stable(esf_sel)) |-> (link_clk_o == !esf_sel)); // R5

   AST_LDATA_HOLD: assert property (@(posedge clk_line) disable iff (!rst_n)
      (link_clk_o && $past(link_clk_o) && !resync && $past(!resync)) |-> $stable(link_data_o)); // R7

   AST_RESYNC_QUIET: assert property (@(posedge clk_line) disable iff (!rst_n)
      resync |-> !(fsync_o || chclk_o || msync_o || sigfr_o || sigsel_o || link_clk_o || link_data_o)); // R9

   AST_SIGSEL_IN_SIGFR: assert property (@(posedge clk_line) disable iff (!rst_n)
      (sigfr_o && !esf_sel) |-> !sigsel_o); // R6
endmodule

bind t1_sf_timing t1tg_checker u_chk (
   .clk_line    (clk_line),
   .rst_n       (rst_n),
   .align_pulse (align_pulse),
   .esf_sel     (esf_sel),
   .resync      (resync),
   .fsync_o     (fsync_o),
   .chclk_o     (chclk_o),
   .msync_o     (msync_o),
   .sigfr_o     (sigfr_o),
   .sigsel_o    (sigsel_o),
   .link_clk_o  (link_clk_o),
   .link_data_o (link_data_o)
);

// File: tb/sim_t1_sf_timing.sv
`timescale 1ns/1ps
module sim_t1_sf_timing;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic align_pulse = 1'b0;
   logic esf_sel = 1'b1;
   logic resync = 1'b0;
   logic line_data = 1'b0;
   logic fsync_o, chclk_o, msync_o, sigfr_o, sigsel_o, link_clk_o, link_data_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   string ph = "-";

   // behavioural reference state
   int  m_b = 0, m_f = 0;
   bit  m_locked = 0, m_hold = 0, m_ld = 0;

   always #4 clk = ~clk;

   t1_sf_timing u0 (
      .clk_line(clk), .rst_n(rst_n), .align_pulse(align_pulse), .esf_sel(esf_sel),
      .resync(resync), .line_data(line_data),
      .fsync_o(fsync_o), .chclk_o(chclk_o), .msync_o(msync_o), .sigfr_o(sigfr_o),
      .sigsel_o(sigsel_o), .link_clk_o(link_clk_o), .link_data_o(link_data_o)
   );

   function automatic bit is_link(int f, bit esf);
      return esf ? (f % 2 == 0) : (f % 2 == 1);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_b = 0; m_f = 0; m_locked = 0; m_hold = 0; m_ld = 0;
      end else begin
         int last;
         last = esf_sel ? 23 : 11;
         if (m_b == 0 && is_link(m_f, esf_sel)) m_hold = line_data;
         if (m_b == 191 && !is_link(m_f, esf_sel)) m_ld = m_hold;
         if (align_pulse) m_locked = 1;
         if (align_pulse) begin
            m_b = 0; m_f = 0;
         end else if (m_b == 192) begin
            m_b = 0;
            m_f = (m_f >= last) ? 0 : m_f + 1;
         end else begin
            m_b = m_b + 1;
         end
      end
   end

   task automatic chk1(string tag, string nm, logic act_v, bit exp_v);
      n_cmp++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s (phase %s) %s actual=%0b expected=%0b t=%0t bit=%0d frame=%0d",
                  tag, ph, nm, act_v, exp_v, $time, m_b, m_f + 1);
      end
   endtask

   task automatic compare_all();
      bit a;
      a = m_locked && !resync && rst_n;
      chk1("R2", "fsync",  fsync_o,  a && m_b == 0);
      chk1("R3", "chclk",  chclk_o,  a && m_b != 0 && ((m_b - 1) % 8) < 4);
      chk1("R4", "msync",  msync_o,  a && m_f < (esf_sel ? 12 : 6));
      chk1("R5", "sigfr",  sigfr_o,  a && (m_f % 6 == 5));
      chk1("R6", "sigsel", sigsel_o, a && (esf_sel ? ((m_f / 6) % 2 == 0) : (m_f % 6 < 3)));
      chk1("R8", "lclk",   link_clk_o, a && is_link(m_f, esf_sel));
      chk1("R7", "ldata",  link_data_o, a && m_ld);
   endtask

   // one cycle: compare at the falling edge, then drive the next inputs
   task automatic run(int n, bit align_first);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare_all();
         line_data   = 1'($urandom % 2);
         align_pulse = (i == 0) && align_first;
      end
   endtask

   initial begin
      ph = "R1";
      run(5, 0);
      @(negedge clk); rst_n = 1'b1;
      run(300, 0);                        // R1: no alignment yet, all low
      ph = "R2";
      run(24 * 193 * 2 + 50, 1);          // extended format
      ph = "R9";
      @(negedge clk); resync = 1'b1;
      run(517, 0);                        // R9: silent while counters run
      @(negedge clk); resync = 1'b0;
      ph = "R9-resume";
      run(24 * 193, 0);
      ph = "R10";
      run(100, 1);                        // R10: realign mid-frame
      run(24 * 193 + 77, 1);
      ph = "R10-sf";
      @(negedge clk); esf_sel = 1'b0;
      run(12 * 193 * 3 + 20, 1);          // superframe with realign at switch
      ph = "R9-sf";
      @(negedge clk); resync = 1'b1;
      run(333, 0);
      @(negedge clk); resync = 1'b0;
      run(12 * 193 * 2, 0);
      ph = "R10-esf";
      @(negedge clk); esf_sel = 1'b1;
      run(24 * 193 * 2, 1);
      ph = "R1-reset";
      @(negedge clk); rst_n = 1'b0;
      run(20, 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired in phase %s", ph);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule